// File: doc/BRIEF.md
# Integer Multiply Execution Unit

This unit carries out the integer multiply operations of a processor pipeline. A full multiply takes two 32-bit values and forms a 64-bit product, signed or unsigned, where the second factor is either a register value or a 9-bit immediate. A halfword multiply takes the low 16 bits of its operands and forms a 32-bit signed product. Its second factor is a register value, a 5-bit immediate, or a 16-bit immediate paired with a source register. No condition flags are produced.

The issue stage presents the operand values, the raw immediate fields, an operation code, the signedness select and two destination register numbers, then pulses `start`. Exactly two cycles later the unit raises `done` for one cycle, together with up to two register-file writes. Port A carries the upper word of a full product, or the halfword product. Port B carries the lower word of a full product. While `busy` is high, a new `start` is ignored.

Top module: `mul_unit`

## Requirements
- R1: With `op` = 0 (full, register), `uns` = 0, the signed 64-bit product of `opb` and `opa` is produced. Its upper word is written on port A to `r3_idx` and its lower word on port B to `r2_idx`.
- R2: With `uns` = 1, the full forms treat both factors as unsigned and give the unsigned 64-bit product.
- R3: With `op` = 1 (full, immediate), the second factor is the 9-bit value {`imm_hi`, `imm_lo`} with `imm_hi` as bits 8:5. It is sign-extended when `uns` = 0 and zero-extended when `uns` = 1.
- R4: With `op` = 2 (halfword, register), the signed product of `opb[15:0]` and `opa[15:0]` is written as 32 bits on port A to `r2_idx`. Port B stays idle. The upper operand bits and `uns` have no effect.
- R5: With `op` = 3 (halfword, short immediate), `opb[15:0]` is multiplied by the sign-extended `imm_lo`. The result goes to `r2_idx` on port A.
- R6: With `op` = 4 (halfword, wide immediate), `opa[15:0]` is multiplied by `imm16`, both signed. The result goes to `r2_idx` on port A.
- R7: A `start` accepted in cycle n gives `busy` high in cycle n+1 only and `done` high in cycle n+2 only. The write enables are high only while `done` is high.
- R8: For a full multiply with `r3_idx` equal to `r2_idx`, only the port A (upper word) write takes place.
- R9: A `start` seen while `busy` is high is ignored. It produces no extra `busy` cycle and no extra `done`. A `start` in the `done` cycle is accepted.
- R10: While `rst_n` is low, `busy`, `done` and both write enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Issue request, sampled when busy is low |
| op | input | 3 | Operation code (0..4, see requirements) |
| uns | input | 1 | Unsigned select for the full forms |
| opa | input | DW | First source register value |
| opb | input | DW | Second source register value |
| imm_lo | input | IMM_LO | Low immediate field (bits 4:0 of the 9-bit value, or the 5-bit immediate) |
| imm_hi | input | IMM_HI | High immediate field (bits 8:5 of the 9-bit value) |
| imm16 | input | HW | Wide halfword immediate |
| r2_idx | input | RW | Register number receiving the low word or the halfword product |
| r3_idx | input | RW | Register number receiving the high word |
| busy | output | 1 | Unit occupied, start ignored |
| done | output | 1 | Result writes valid this cycle |
| wa_we | output | 1 | Port A write enable |
| wa_idx | output | RW | Port A register number |
| wa_data | output | DW | Port A write data |
| wb_we | output | 1 | Port B write enable |
| wb_idx | output | RW | Port B register number |
| wb_data | output | DW | Port B write data |

## Verification
The bench multiplies all-ones operands in both signed and unsigned modes, along with the most negative word squared. A design that extends the sign wrongly turns 1 into 0xFFFFFFFE_00000001, or corrupts the high word. It drives a 9-bit immediate of 0x100 in both modes and fills the upper halves of halfword operands with noise, which catches swapped immediate fields and the use of bits that must be ignored. It repeats a destination number on a full multiply, where a design that writes both ports would let the low word clobber the high one. It also holds `start` high across several cycles, where a unit that accepts during `busy` would produce extra or misplaced completions.

// File: rtl/mul_pkg.sv
package mul_pkg;

   typedef enum logic [2:0] {
      MOP_FULL_REG   = 3'd0,
      MOP_FULL_IMM   = 3'd1,
      MOP_HALF_REG   = 3'd2,
      MOP_HALF_IMM5  = 3'd3,
      MOP_HALF_IMM16 = 3'd4
   } mop_e;

   function automatic logic mop_is_full(input logic [2:0] code);
      return (code == MOP_FULL_REG) || (code == MOP_FULL_IMM);
   endfunction

endpackage

// File: rtl/mul_opsel.sv
module mul_opsel
   import mul_pkg::*;
#(
   parameter int DW     = 32,
   parameter int HW     = 16,
   parameter int IMM_LO = 5,
   parameter int IMM_HI = 4
) (
   input  logic [2:0]        op,
   input  logic              uns,
   input  logic [DW-1:0]     opa,
   input  logic [DW-1:0]     opb,
   input  logic [IMM_LO-1:0] imm_lo,
   input  logic [IMM_HI-1:0] imm_hi,
   input  logic [HW-1:0]     imm16,
   output logic [DW:0]       fac_x,
   output logic [DW:0]       fac_y
);
   localparam int IW = IMM_LO + IMM_HI;

   logic [IW-1:0] imm_wide;
   logic [DW:0]   full_a, full_b, half_a, half_b, wide_imm_x, short_imm_x, imm16_x;

   assign imm_wide    = {imm_hi, imm_lo};
   assign full_a      = {~uns & opa[DW-1], opa};
   assign full_b      = {~uns & opb[DW-1], opb};
   assign half_a      = {{(DW+1-HW){opa[HW-1]}}, opa[HW-1:0]};
   assign half_b      = {{(DW+1-HW){opb[HW-1]}}, opb[HW-1:0]};
   assign wide_imm_x  = {{(DW+1-IW){~uns & imm_wide[IW-1]}}, imm_wide};
   assign short_imm_x = {{(DW+1-IMM_LO){imm_lo[IMM_LO-1]}}, imm_lo};
   assign imm16_x     = {{(DW+1-HW){imm16[HW-1]}}, imm16};

   always_comb begin
      unique case (mop_e'(op))
         MOP_FULL_IMM:   begin fac_x = full_b; fac_y = wide_imm_x;  end
         MOP_HALF_REG:   begin fac_x = half_b; fac_y = half_a;      end
         MOP_HALF_IMM5:  begin fac_x = half_b; fac_y = short_imm_x; end
         MOP_HALF_IMM16: begin fac_x = half_a; fac_y = imm16_x;     end
         default:        begin fac_x = full_b; fac_y = full_a;      end
      endcase
   end

endmodule

// File: rtl/mul_core.sv
module mul_core #(
   parameter int DW           = 32,
   parameter int SBW          = 11,
   parameter bit REG_OPERANDS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_vld,
   input  logic [DW:0]     fac_x,
   input  logic [DW:0]     fac_y,
   input  logic [SBW-1:0]  sb_in,
   output logic            mid_vld,
   output logic            out_vld,
   output logic [2*DW-1:0] prod,
   output logic [SBW-1:0]  sb_out
);
   localparam int PW = 2 * DW;

   logic [SBW-1:0] sb_mid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mid_vld <= 1'b0;
         out_vld <= 1'b0;
      end else begin
         mid_vld <= in_vld;
         out_vld <= mid_vld;
      end
   end

   always_ff @(posedge clk) begin
      sb_mid <= sb_in;
      sb_out <= sb_mid;
   end

   generate
      if (REG_OPERANDS) begin : g_opreg
         logic [DW:0]          x_q, y_q;
         logic signed [PW-1:0] x_w, y_w;
         assign x_w = {{(DW-1){x_q[DW]}}, x_q};
         assign y_w = {{(DW-1){y_q[DW]}}, y_q};
         always_ff @(posedge clk) begin
            x_q  <= fac_x;
            y_q  <= fac_y;
            prod <= x_w * y_w;
         end
      end else begin : g_prodreg
         logic signed [PW-1:0] x_w, y_w;
         logic [PW-1:0]        p_q;
         assign x_w = {{(DW-1){fac_x[DW]}}, fac_x};
         assign y_w = {{(DW-1){fac_y[DW]}}, fac_y};
         always_ff @(posedge clk) begin
            p_q  <= x_w * y_w;
            prod <= p_q;
         end
      end
   endgenerate

endmodule

// File: rtl/mul_wrback.sv
module mul_wrback #(
   parameter int DW = 32,
   parameter int RW = 5
) (
   input  logic            vld,
   input  logic            is_full,
   input  logic [RW-1:0]   hi_dst,
   input  logic [RW-1:0]   lo_dst,
   input  logic [2*DW-1:0] prod,
   output logic            wa_we,
   output logic [RW-1:0]   wa_idx,
   output logic [DW-1:0]   wa_data,
   output logic            wb_we,
   output logic [RW-1:0]   wb_idx,
   output logic [DW-1:0]   wb_data
);
   assign wa_we   = vld;
   assign wa_idx  = is_full ? hi_dst : lo_dst;
   assign wa_data = is_full ? prod[2*DW-1:DW] : prod[DW-1:0];
   assign wb_we   = vld & is_full & (hi_dst != lo_dst);
   assign wb_idx  = lo_dst;
   assign wb_data = prod[DW-1:0];
endmodule

// File: rtl/mul_unit.sv
module mul_unit
   import mul_pkg::*;
#(
   parameter int DW           = 32,
   parameter int HW           = 16,
   parameter int IMM_LO       = 5,
   parameter int IMM_HI       = 4,
   parameter int RW           = 5,
   parameter bit REG_OPERANDS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [2:0]        op,
   input  logic              uns,
   input  logic [DW-1:0]     opa,
   input  logic [DW-1:0]     opb,
   input  logic [IMM_LO-1:0] imm_lo,
   input  logic [IMM_HI-1:0] imm_hi,
   input  logic [HW-1:0]     imm16,
   input  logic [RW-1:0]     r2_idx,
   input  logic [RW-1:0]     r3_idx,
   output logic              busy,
   output logic              done,
   output logic              wa_we,
   output logic [RW-1:0]     wa_idx,
   output logic [DW-1:0]     wa_data,
   output logic              wb_we,
   output logic [RW-1:0]     wb_idx,
   output logic [DW-1:0]     wb_data
);
   localparam int SBW = 1 + 2 * RW;

   if (DW != 2 * HW) begin : g_bad_half
      $error("mul_unit: DW must be twice HW");
   end
   if (IMM_LO + IMM_HI >= DW || IMM_LO >= HW) begin : g_bad_imm
      $error("mul_unit: immediate fields too wide");
   end

   logic [DW:0]     fac_x, fac_y;
   logic            accept;
   logic [SBW-1:0]  sb_in, sb_out;
   logic [2*DW-1:0] prod;

   assign accept = start & ~busy;
   assign sb_in  = {mop_is_full(op), r3_idx, r2_idx};

   mul_opsel #(.DW(DW), .HW(HW), .IMM_LO(IMM_LO), .IMM_HI(IMM_HI)) u_opsel (
      .op(op), .uns(uns), .opa(opa), .opb(opb),
      .imm_lo(imm_lo), .imm_hi(imm_hi), .imm16(imm16),
      .fac_x(fac_x), .fac_y(fac_y)
   );

   mul_core #(.DW(DW), .SBW(SBW), .REG_OPERANDS(REG_OPERANDS)) u_core (
      .clk(clk), .rst_n(rst_n), .in_vld(accept),
      .fac_x(fac_x), .fac_y(fac_y), .sb_in(sb_in),
      .mid_vld(busy), .out_vld(done), .prod(prod), .sb_out(sb_out)
   );

   mul_wrback #(.DW(DW), .RW(RW)) u_wrback (
      .vld(done), .is_full(sb_out[SBW-1]),
      .hi_dst(sb_out[2*RW-1:RW]), .lo_dst(sb_out[RW-1:0]), .prod(prod),
      .wa_we(wa_we), .wa_idx(wa_idx), .wa_data(wa_data),
      .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data)
   );

endmodule

// File: rtl/mul_unit_chk.sv
module mul_unit_chk #(
   parameter int RW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic          wa_we,
   input logic [RW-1:0] wa_idx,
   input logic          wb_we,
   input logic [RW-1:0] wb_idx
);
   AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                   // R7
   AST_DONE_FOLLOWS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));                                        // R7
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                              // R7
   AST_WRITES_ONLY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (wa_we || wb_we) |-> done);                                   // R7
   AST_BUSY_NOT_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);                                              // R9
   AST_PORTS_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
      (wa_we && wb_we) |-> (wa_idx != wb_idx));                     // R8
   AST_HI_WRITE_WITH_LO: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we |-> wa_we);                                             // R1
endmodule

bind mul_unit mul_unit_chk #(.RW(RW)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .wa_we(wa_we), .wa_idx(wa_idx), .wb_we(wb_we), .wb_idx(wb_idx)
);

// File: tb/mul_unit_tb_top.sv
module mul_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic        uns = 1'b0;
   logic [31:0] opa = '0, opb = '0;
   logic [4:0]  imm_lo = '0;
   logic [3:0]  imm_hi = '0;
   logic [15:0] imm16 = '0;
   logic [4:0]  r2_idx = '0, r3_idx = '0;
   logic        busy, done, wa_we, wb_we;
   logic [4:0]  wa_idx, wb_idx;
   logic [31:0] wa_data, wb_data;

   int n_total = 0;
   int n_fail  = 0;
   int cyc     = 0;
   string cur_tag = "R10";

   typedef struct {
      int          due;
      string       tag;
      logic [4:0]  a_idx;
      logic [31:0] a_data;
      logic        b_we;
      logic [4:0]  b_idx;
      logic [31:0] b_data;
   } exp_t;

   exp_t q[$];

   always #10 clk = ~clk;

   mul_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .uns(uns),
      .opa(opa), .opb(opb), .imm_lo(imm_lo), .imm_hi(imm_hi), .imm16(imm16),
      .r2_idx(r2_idx), .r3_idx(r3_idx), .busy(busy), .done(done),
      .wa_we(wa_we), .wa_idx(wa_idx), .wa_data(wa_data),
      .wb_we(wb_we), .wb_idx(wb_idx), .wb_data(wb_data)
   );

   task automatic chk(input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t calc(input int due);
      exp_t e;
      logic [63:0] p;
      logic [8:0]  iw;
      int          h;
      iw = {imm_hi, imm_lo};
      e.due = due;
      e.b_we = 1'b0;
      e.b_idx = r2_idx;
      e.b_data = '0;
      case (op)
         3'd0, 3'd1: begin
            if (op == 3'd0) begin
               if (uns) p = {32'b0, opb} * {32'b0, opa};
               else     p = longint'($signed(opb)) * longint'($signed(opa));
               e.tag = uns ? "R2" : "R1";
            end else begin
               if (uns) p = {32'b0, opb} * {55'b0, iw};
               else     p = longint'($signed(opb)) * longint'($signed(iw));
               e.tag = "R3";
            end
            e.a_idx  = r3_idx;
            e.a_data = p[63:32];
            e.b_data = p[31:0];
            e.b_we   = (r3_idx != r2_idx);
            if (r3_idx == r2_idx) e.tag = "R8";
         end
         default: begin
            if (op == 3'd2) begin
               h = int'(shortint'(opb[15:0])) * int'(shortint'(opa[15:0]));
               e.tag = "R4";
            end else if (op == 3'd3) begin
               h = int'(shortint'(opb[15:0])) * int'($signed(imm_lo));
               e.tag = "R5";
            end else begin
               h = int'(shortint'(opa[15:0])) * int'(shortint'(imm16));
               e.tag = "R6";
            end
            e.a_idx  = r2_idx;
            e.a_data = h;
         end
      endcase
      return e;
   endfunction

   // Reference model: advanced on each rising edge from the inputs then held.
   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) q.delete();
      else begin
         while (q.size() > 0 && q[0].due < cyc) void'(q.pop_front());
         if (start && !(q.size() > 0 && q[q.size()-1].due == cyc))
            q.push_back(calc(cyc + 1));
      end
   end

   // Compare on every falling edge.
   always @(negedge clk) begin
      logic exp_done, exp_busy;
      exp_done = (q.size() > 0 && q[0].due == cyc);
      exp_busy = (q.size() > 0 && q[q.size()-1].due == cyc + 1);
      chk(cur_tag, "busy", 64'(busy), 64'(exp_busy));
      chk(cur_tag, "done", 64'(done), 64'(exp_done));
      if (exp_done) begin
         chk(q[0].tag, "wa_we",   64'(wa_we),   64'd1);
         chk(q[0].tag, "wa_idx",  64'(wa_idx),  64'(q[0].a_idx));
         chk(q[0].tag, "wa_data", 64'(wa_data), 64'(q[0].a_data));
         chk(q[0].tag, "wb_we",   64'(wb_we),   64'(q[0].b_we));
         if (q[0].b_we) begin
            chk(q[0].tag, "wb_idx",  64'(wb_idx),  64'(q[0].b_idx));
            chk(q[0].tag, "wb_data", 64'(wb_data), 64'(q[0].b_data));
         end
      end else begin
         chk(cur_tag, "wa_we idle", 64'(wa_we), 64'd0);
         chk(cur_tag, "wb_we idle", 64'(wb_we), 64'd0);
      end
   end

   task automatic issue(input logic [2:0] o, input logic u,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [8:0] iw, input logic [15:0] i16,
                        input logic [4:0] d2, input logic [4:0] d3);
      op = o; uns = u; opa = a; opb = b;
      imm_lo = iw[4:0]; imm_hi = iw[8:5]; imm16 = i16;
      r2_idx = d2; r3_idx = d3;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      cur_tag = "R10";
      start = 1'b1;
      repeat (3) @(negedge clk);
      start = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      cur_tag = "R7";
      // R1 signed full register form
      issue(3'd0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 9'd0, 16'd0, 5'd2, 5'd3);
      issue(3'd0, 1'b0, 32'h8000_0000, 32'h8000_0000, 9'd0, 16'd0, 5'd4, 5'd5);
      issue(3'd0, 1'b0, 32'h1234_5678, 32'hFEDC_BA98, 9'd0, 16'd0, 5'd6, 5'd7);
      // R2 unsigned full register form
      issue(3'd0, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 9'd0, 16'd0, 5'd2, 5'd3);
      issue(3'd0, 1'b1, 32'h8000_0000, 32'h0000_0003, 9'd0, 16'd0, 5'd8, 5'd9);
      // R3 nine-bit immediate, both extensions
      issue(3'd1, 1'b0, 32'hDEAD_BEEF, 32'h0000_1000, 9'h100, 16'd0, 5'd1, 5'd10);
      issue(3'd1, 1'b1, 32'hDEAD_BEEF, 32'h0000_1000, 9'h100, 16'd0, 5'd1, 5'd10);
      issue(3'd1, 1'b0, 32'h0, 32'hFFFF_FFF0, 9'h0A5, 16'd0, 5'd11, 5'd12);
      issue(3'd1, 1'b1, 32'h0, 32'hFFFF_FFF0, 9'h1FF, 16'd0, 5'd11, 5'd12);
      // R4 halfword register form, noise in upper bits, uns ignored
      issue(3'd2, 1'b0, 32'hABCD_8000, 32'h1234_8000, 9'd0, 16'd0, 5'd13, 5'd14);
      issue(3'd2, 1'b1, 32'h5555_FFFF, 32'hAAAA_7FFF, 9'd0, 16'd0, 5'd15, 5'd16);
      // R5 halfword short immediate
      issue(3'd3, 1'b0, 32'h0, 32'hFFFF_0123, 9'h010, 16'd0, 5'd17, 5'd18);
      issue(3'd3, 1'b0, 32'h0, 32'h0000_8000, 9'h00F, 16'd0, 5'd17, 5'd18);
      // R6 halfword wide immediate
      issue(3'd4, 1'b0, 32'h7777_8000, 32'h0, 9'd0, 16'h8000, 5'd19, 5'd20);
      issue(3'd4, 1'b0, 32'h0000_0321, 32'hFFFF_FFFF, 9'd0, 16'h7FFF, 5'd21, 5'd22);
      // R8 same destination on a full multiply
      issue(3'd0, 1'b0, 32'h0001_0000, 32'hFFFF_0000, 9'd0, 16'd0, 5'd9, 5'd9);
      issue(3'd1, 1'b1, 32'h0, 32'hF000_0000, 9'h1FF, 16'd0, 5'd31, 5'd31);
      // R9 start held high across busy cycles
      cur_tag = "R9";
      op = 3'd0; uns = 1'b0; opa = 32'h0000_0007; opb = 32'hFFFF_FFFD;
      r2_idx = 5'd2; r3_idx = 5'd3;
      start = 1'b1;
      repeat (6) @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      cur_tag = "R7";
      for (int i = 0; i < 40; i++) begin
         issue(3'($urandom_range(0, 4)), 1'($urandom), $urandom, $urandom,
               9'($urandom), 16'($urandom), 5'($urandom), 5'($urandom));
      end
      repeat (3) @(negedge clk);
      // R10 reset mid-operation clears control outputs
      cur_tag = "R10";
      op = 3'd0; start = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      start = 1'b0;
      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule